// File: doc/BRIEF.md
# Triggered Command-Set Sequencer Bank

This block holds a bank of command sets behind a word-addressed register interface. Each set has a fixed number of command slots. Every slot stores a message word, a target address, a data word, a status word and a captured response word. Software fills the slots of a set, picks which slots take part with a per-set enable mask, and starts the set with a two-step control sequence. The mode-enable bit must already be stored before the trigger bit rises.

A single issue engine serves the started sets one at a time. It sends each enabled slot of a set in ascending slot order on a request/accept output bus, and records per-slot issued and completed flags. A slot counts as response-required when its message word asks for a response or the set's wait mask has its bit set. For such a slot the engine waits for a response strobe before moving on, and it stores the returned data. When the last enabled slot of a set completes, the set returns to idle and its bit in the shared interrupt status register is set. That bit drives the interrupt line only when the matching interrupt enable bit is set. It is cleared by writing a one to the clear register.

Top module: `cmdseq_bank`

## Requirements
- R1: Map, byte addresses: set s starts at s*672. Its wait mask is at +0x10, control at +0x14, status at +0x18 and slot enable mask at +0x1C. Slot j fields start at s*672+0x30+20*j: message +0x0, address +0x4, data +0x8, slot status +0xC, response +0x10. Interrupt enable, status and clear are at 0x00, 0x04 and 0x08, with bit s for set s. After reset all registers read zero, except that the set status reads 1 (bit 0 = idle).
- R2: A set starts only on a control write that sets the trigger bit (24) and the mode-enable bit (16), while the stored trigger bit is 0, the stored enable bit is already 1, and the set is idle. Any other control write starts nothing.
- R3: A started set issues exactly its enabled slots, in ascending slot index, each carrying that slot's address and data on the bus.
- R4: Once asserted, the bus request and its payload stay unchanged until the accept input is high at a clock edge.
- R5: A slot is response-required when message bit 8 or its wait-mask bit is 1. The bus message then shows bit 8 set, no further request is made until a response strobe arrives, and the response data is stored in the slot's response register. Other slots complete on accept.
- R6: Slot status bit 8 is set when the slot is accepted and bit 16 when it completes.
- R7: While a set is busy its status register reads 0, and writes to its slot fields, slot enable mask and wait mask are ignored.
- R8: When a set's last enabled slot completes, or at once if it has no enabled slot, the set returns to idle and sets its interrupt status bit. The interrupt output is high when any status bit is set together with its enable bit. Writing a 1 to a clear bit clears that status bit.
- R9: Writing a set's enable mask with bit j equal to 0, while the set is idle, clears both status flags of slot j.
- R10: Started sets wait their turn. When the engine is free it takes the lowest-index busy set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| cmd_req | output | 1 | Command request |
| cmd_gnt | input | 1 | Command accepted this cycle |
| cmd_msgid | output | 32 | Message word of the current slot, bit 8 forced for response-required slots |
| cmd_addr | output | 32 | Target address of the current slot |
| cmd_data | output | 32 | Data of the current slot |
| cmd_rsp_vld | input | 1 | Response strobe for the outstanding response-required slot |
| cmd_rsp_data | input | 32 | Response data |
| irq | output | 1 | Done interrupt |

## Verification
The assertions take for granted that the responder raises the response strobe only while a response-required slot is outstanding, and never in the same cycle as the accept for that slot. They also take for granted that register writes are word aligned. The bench responder satisfies both. It counts down a response delay of at least one cycle after an accept that carries message bit 8, it grants nothing while that countdown runs, and every address the bench writes is a multiple of four taken from the map in R1.

// File: rtl/cmdseq_pkg.sv
// Package: shared register map offsets, bit positions and enum types for
// the command-set sequencer bank. Assumes 32-bit registers, byte addresses.
package cmdseq_pkg;

    localparam int unsigned SET_STRIDE  = 672;
    localparam int unsigned SLOT_BASE   = 'h30;
    localparam int unsigned SLOT_STRIDE = 20;

    localparam int unsigned OFF_IRQ_EN  = 'h00;
    localparam int unsigned OFF_IRQ_STS = 'h04;
    localparam int unsigned OFF_IRQ_CLR = 'h08;
    localparam int unsigned OFF_WAITM   = 'h10;
    localparam int unsigned OFF_CTRL    = 'h14;
    localparam int unsigned OFF_STAT    = 'h18;
    localparam int unsigned OFF_SLOTEN  = 'h1C;

    localparam int unsigned FLD_MSG  = 'h0;
    localparam int unsigned FLD_ADDR = 'h4;
    localparam int unsigned FLD_DATA = 'h8;
    localparam int unsigned FLD_STAT = 'hC;
    localparam int unsigned FLD_RSP  = 'h10;

    localparam int CTRL_EN_BIT   = 16;
    localparam int CTRL_TRIG_BIT = 24;
    localparam int MSG_RR_BIT    = 8;
    localparam int ST_ISS_BIT    = 8;
    localparam int ST_CMPL_BIT   = 16;

    typedef enum logic [3:0] {
        RK_NONE, RK_IRQ_EN, RK_IRQ_STS, RK_IRQ_CLR,
        RK_WAITM, RK_CTRL, RK_STAT, RK_SLOTEN,
        RK_S_MSG, RK_S_ADDR, RK_S_DATA, RK_S_STAT, RK_S_RSP
    } reg_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_ISSUE, SQ_WAITR
    } seq_state_e;

endpackage

// File: rtl/cmdseq_ffs.sv
// Find-first-set: returns the lowest set bit index of a vector.
// Assumes IW is wide enough to hold N-1.
module cmdseq_ffs #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cmdseq_decode.sv
// Register address decoder: turns a byte address into a register kind,
// a set index and a slot index. Assumes word-aligned accesses; any other
// address decodes to RK_NONE.
module cmdseq_decode
    import cmdseq_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int SLOTS    = 4,
    parameter int REG_AW   = 12,
    parameter int SET_W    = 1,
    parameter int SLOT_W   = 2
) (
    input  logic [REG_AW-1:0] addr,
    output reg_kind_e         kind,
    output logic [SET_W-1:0]  set_idx,
    output logic [SLOT_W-1:0] slot_idx
);
    int unsigned a, s, o, r, j, f;

    // Split the address into set, offset in set, slot and field.
    always_comb begin
        a = 32'(addr);
        s = a / SET_STRIDE;
        o = a % SET_STRIDE;
        r = (o >= SLOT_BASE) ? (o - SLOT_BASE) : 0;
        j = r / SLOT_STRIDE;
        f = r % SLOT_STRIDE;
        kind     = RK_NONE;
        set_idx  = s[SET_W-1:0];
        slot_idx = j[SLOT_W-1:0];
        if (a[1:0] == 2'b00 && s < NUM_SETS) begin
            if (o < OFF_WAITM) begin
                if (s == 0) begin
                    case (o)
                        OFF_IRQ_EN:  kind = RK_IRQ_EN;
                        OFF_IRQ_STS: kind = RK_IRQ_STS;
                        OFF_IRQ_CLR: kind = RK_IRQ_CLR;
                        default:     kind = RK_NONE;
                    endcase
                end
            end else if (o < SLOT_BASE) begin
                case (o)
                    OFF_WAITM:  kind = RK_WAITM;
                    OFF_CTRL:   kind = RK_CTRL;
                    OFF_STAT:   kind = RK_STAT;
                    OFF_SLOTEN: kind = RK_SLOTEN;
                    default:    kind = RK_NONE;
                endcase
            end else if (j < SLOTS) begin
                case (f)
                    FLD_MSG:  kind = RK_S_MSG;
                    FLD_ADDR: kind = RK_S_ADDR;
                    FLD_DATA: kind = RK_S_DATA;
                    FLD_STAT: kind = RK_S_STAT;
                    FLD_RSP:  kind = RK_S_RSP;
                    default:  kind = RK_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmdseq_engine.sv
// Issue engine: picks the lowest busy set, walks its enabled slots in
// ascending order, drives the request, waits for a response on
// response-required slots, and pulses a one-hot done per finished set.
// Assumes busy sets keep their enable masks frozen (enforced by the top)
// and that rsp_vld comes only while a response is outstanding.
module cmdseq_engine
    import cmdseq_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int SLOTS    = 4,
    parameter int SET_W    = 1,
    parameter int SLOT_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SETS-1:0] busy,
    input  logic [SLOTS-1:0]    en_mask [NUM_SETS],
    input  logic                cur_rr,
    input  logic                cmd_gnt,
    input  logic                cmd_rsp_vld,
    output logic                cmd_req,
    output logic [SET_W-1:0]    cur_set,
    output logic [SLOT_W-1:0]   cur_slot,
    output logic                mark_issue,
    output logic                mark_cmpl,
    output logic                cap_rsp,
    output logic [NUM_SETS-1:0] set_done
);
    seq_state_e          state_q;
    logic                any_busy, slot_found, finish;
    logic [SET_W-1:0]    pick_set, done_idx;
    logic [SLOT_W-1:0]   slot_idx;
    logic [SLOTS-1:0]    above, sel_mask;

    cmdseq_ffs #(.N(NUM_SETS), .IW(SET_W)) u_set_pick (
        .vec(busy), .found(any_busy), .idx(pick_set)
    );

    cmdseq_ffs #(.N(SLOTS), .IW(SLOT_W)) u_slot_find (
        .vec(sel_mask), .found(slot_found), .idx(slot_idx)
    );

    // Slot search window: all enabled slots when idle, else those above current.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) above[i] = (i > int'(cur_slot));
        sel_mask = (state_q == SQ_IDLE) ? en_mask[pick_set]
                                        : (en_mask[cur_set] & above);
    end

    // Handshake strobes and set-completion pulse.
    always_comb begin
        cmd_req    = (state_q == SQ_ISSUE);
        mark_issue = cmd_req && cmd_gnt;
        cap_rsp    = (state_q == SQ_WAITR) && cmd_rsp_vld;
        mark_cmpl  = (mark_issue && !cur_rr) || cap_rsp;
        finish     = ((state_q == SQ_IDLE) && any_busy && !slot_found) ||
                     (mark_cmpl && !slot_found);
        done_idx   = (state_q == SQ_IDLE) ? pick_set : cur_set;
        set_done   = finish ? (NUM_SETS'(1) << done_idx) : '0;
    end

    // Sequencer state and current set/slot pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            cur_set  <= '0;
            cur_slot <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (any_busy) begin
                    cur_set <= pick_set;
                    if (slot_found) begin
                        cur_slot <= slot_idx;
                        state_q  <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: if (cmd_gnt) begin
                    if (cur_rr)          state_q  <= SQ_WAITR;
                    else if (slot_found) cur_slot <= slot_idx;
                    else                 state_q  <= SQ_IDLE;
                end
                SQ_WAITR: if (cmd_rsp_vld) begin
                    if (slot_found) begin
                        cur_slot <= slot_idx;
                        state_q  <= SQ_ISSUE;
                    end else begin
                        state_q  <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_gnt) |=> (cmd_req && $stable(cur_set) && $stable(cur_slot)));

    assert_wait_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_gnt && cur_rr) |=> !cmd_req);

    assert_one_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_done));
endmodule

// File: rtl/cmdseq_bank.sv
// Top: command-set storage, register access, start qualification,
// interrupt registers and bus payload mux around the issue engine.
// Assumes word-aligned register writes; reads are combinational.
module cmdseq_bank
    import cmdseq_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int SLOTS    = 4,
    parameter int REG_AW   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmd_req,
    input  logic              cmd_gnt,
    output logic [31:0]       cmd_msgid,
    output logic [31:0]       cmd_addr,
    output logic [31:0]       cmd_data,
    input  logic              cmd_rsp_vld,
    input  logic [31:0]       cmd_rsp_data,
    output logic              irq
);
    localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    reg_kind_e          dec_kind;
    logic [SET_W-1:0]   dec_set, cur_set;
    logic [SLOT_W-1:0]  dec_slot, cur_slot;

    logic [31:0]        msg_q  [NUM_SETS][SLOTS];
    logic [31:0]        addr_q [NUM_SETS][SLOTS];
    logic [31:0]        data_q [NUM_SETS][SLOTS];
    logic [31:0]        rsp_q  [NUM_SETS][SLOTS];
    logic [SLOTS-1:0]   iss_q  [NUM_SETS];
    logic [SLOTS-1:0]   cmpl_q [NUM_SETS];
    logic [SLOTS-1:0]   waitm_q [NUM_SETS];
    logic [SLOTS-1:0]   sloten_q [NUM_SETS];
    logic [NUM_SETS-1:0] ctrl_en_q, ctrl_trig_q, busy_q, start_v, set_done;
    logic [NUM_SETS-1:0] irq_en_q, irq_sts_q;
    logic               cur_rr, mark_issue, mark_cmpl, cap_rsp;

    cmdseq_decode #(
        .NUM_SETS(NUM_SETS), .SLOTS(SLOTS), .REG_AW(REG_AW),
        .SET_W(SET_W), .SLOT_W(SLOT_W)
    ) u_decode (
        .addr(reg_addr), .kind(dec_kind), .set_idx(dec_set), .slot_idx(dec_slot)
    );

    cmdseq_engine #(
        .NUM_SETS(NUM_SETS), .SLOTS(SLOTS), .SET_W(SET_W), .SLOT_W(SLOT_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .busy(busy_q), .en_mask(sloten_q),
        .cur_rr(cur_rr), .cmd_gnt(cmd_gnt), .cmd_rsp_vld(cmd_rsp_vld),
        .cmd_req(cmd_req), .cur_set(cur_set), .cur_slot(cur_slot),
        .mark_issue(mark_issue), .mark_cmpl(mark_cmpl), .cap_rsp(cap_rsp),
        .set_done(set_done)
    );

    // Start qualification: trigger rising while enable is already stored.
    always_comb begin
        for (int s = 0; s < NUM_SETS; s++) begin
            start_v[s] = reg_wr && (dec_kind == RK_CTRL) && (dec_set == SET_W'(s)) &&
                         reg_wdata[CTRL_TRIG_BIT] && reg_wdata[CTRL_EN_BIT] &&
                         ctrl_en_q[s] && !ctrl_trig_q[s] && !busy_q[s];
        end
    end

    // Per-set control, masks and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q   <= '0;
            ctrl_trig_q <= '0;
            busy_q      <= '0;
            for (int s = 0; s < NUM_SETS; s++) begin
                waitm_q[s]  <= '0;
                sloten_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < NUM_SETS; s++) begin
                if (reg_wr && dec_set == SET_W'(s)) begin
                    if (dec_kind == RK_CTRL) begin
                        ctrl_en_q[s]   <= reg_wdata[CTRL_EN_BIT];
                        ctrl_trig_q[s] <= reg_wdata[CTRL_TRIG_BIT];
                    end
                    if (!busy_q[s] && dec_kind == RK_WAITM)  waitm_q[s]  <= reg_wdata[SLOTS-1:0];
                    if (!busy_q[s] && dec_kind == RK_SLOTEN) sloten_q[s] <= reg_wdata[SLOTS-1:0];
                end
                if (start_v[s])       busy_q[s] <= 1'b1;
                else if (set_done[s]) busy_q[s] <= 1'b0;
            end
        end
    end

    // Slot storage: software writes when idle, engine updates status/response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                iss_q[s]  <= '0;
                cmpl_q[s] <= '0;
                for (int j = 0; j < SLOTS; j++) begin
                    msg_q[s][j]  <= '0;
                    addr_q[s][j] <= '0;
                    data_q[s][j] <= '0;
                    rsp_q[s][j]  <= '0;
                end
            end
        end else begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int j = 0; j < SLOTS; j++) begin
                    if (reg_wr && !busy_q[s] && dec_set == SET_W'(s) &&
                        dec_slot == SLOT_W'(j)) begin
                        case (dec_kind)
                            RK_S_MSG:  msg_q[s][j]  <= reg_wdata;
                            RK_S_ADDR: addr_q[s][j] <= reg_wdata;
                            RK_S_DATA: data_q[s][j] <= reg_wdata;
                            default: ;
                        endcase
                    end
                    if (cur_set == SET_W'(s) && cur_slot == SLOT_W'(j)) begin
                        if (mark_issue) iss_q[s][j]  <= 1'b1;
                        if (mark_cmpl)  cmpl_q[s][j] <= 1'b1;
                        if (cap_rsp)    rsp_q[s][j]  <= cmd_rsp_data;
                    end
                    if (reg_wr && !busy_q[s] && dec_kind == RK_SLOTEN &&
                        dec_set == SET_W'(s) && !reg_wdata[j]) begin
                        iss_q[s][j]  <= 1'b0;
                        cmpl_q[s][j] <= 1'b0;
                    end
                end
            end
        end
    end

    // Interrupt enable and sticky status with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q  <= '0;
            irq_sts_q <= '0;
        end else begin
            if (reg_wr && dec_kind == RK_IRQ_EN) irq_en_q <= reg_wdata[NUM_SETS-1:0];
            irq_sts_q <= (irq_sts_q &
                          ~((reg_wr && dec_kind == RK_IRQ_CLR) ? reg_wdata[NUM_SETS-1:0]
                                                               : '0)) | set_done;
        end
    end

    assign irq = |(irq_en_q & irq_sts_q);

    // Bus payload of the current slot; response-required forces message bit 8.
    always_comb begin
        cur_rr    = msg_q[cur_set][cur_slot][MSG_RR_BIT] | waitm_q[cur_set][cur_slot];
        cmd_msgid = msg_q[cur_set][cur_slot];
        cmd_msgid[MSG_RR_BIT] = cur_rr;
        cmd_addr  = addr_q[cur_set][cur_slot];
        cmd_data  = data_q[cur_set][cur_slot];
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (dec_kind)
            RK_IRQ_EN:  reg_rdata[NUM_SETS-1:0] = irq_en_q;
            RK_IRQ_STS: reg_rdata[NUM_SETS-1:0] = irq_sts_q;
            RK_WAITM:   reg_rdata[SLOTS-1:0]    = waitm_q[dec_set];
            RK_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = ctrl_en_q[dec_set];
                reg_rdata[CTRL_TRIG_BIT] = ctrl_trig_q[dec_set];
            end
            RK_STAT:    reg_rdata[0]            = !busy_q[dec_set];
            RK_SLOTEN:  reg_rdata[SLOTS-1:0]    = sloten_q[dec_set];
            RK_S_MSG:   reg_rdata = msg_q[dec_set][dec_slot];
            RK_S_ADDR:  reg_rdata = addr_q[dec_set][dec_slot];
            RK_S_DATA:  reg_rdata = data_q[dec_set][dec_slot];
            RK_S_STAT: begin
                reg_rdata[ST_ISS_BIT]  = iss_q[dec_set][dec_slot];
                reg_rdata[ST_CMPL_BIT] = cmpl_q[dec_set][dec_slot];
            end
            RK_S_RSP:   reg_rdata = rsp_q[dec_set][dec_slot];
            default:    reg_rdata = '0;
        endcase
    end

    for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set_chk
        assert_start_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_q[gs]) |-> $past(ctrl_en_q[gs]));

        assert_irq_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_done[gs] |=> irq_sts_q[gs]);

        for (genvar gj = 0; gj < SLOTS; gj++) begin : g_slot_chk
            assert_slot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
                busy_q[gs] |=> ($stable(addr_q[gs][gj]) && $stable(msg_q[gs][gj])));
        end
    end
endmodule

// File: tb/cmdseq_bank_tb.sv
module cmdseq_bank_tb;
    localparam int NS = 3;
    localparam int NSL = 4;
    localparam logic [31:0] RSP_X = 32'h5A5A0000;
    localparam logic [31:0] ST_DONE = 32'h0001_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_req, cmd_gnt = 1'b0, cmd_rsp_vld = 1'b0, irq;
    logic [31:0] cmd_msgid, cmd_addr, cmd_data, cmd_rsp_data = '0;

    int n_chk = 0, n_fail = 0, n_gnt = 0;
    int gnt_delay = 0, rsp_delay = 2;
    bit finished = 0;
    logic [95:0] exp_q[$];

    cmdseq_bank #(.NUM_SETS(NS), .SLOTS(NSL), .REG_AW(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_req(cmd_req),
        .cmd_gnt(cmd_gnt), .cmd_msgid(cmd_msgid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_rsp_vld(cmd_rsp_vld),
        .cmd_rsp_data(cmd_rsp_data), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic int unsigned a_set(int s, int off);
        return s * 672 + off;
    endfunction

    function automatic int unsigned a_slot(int s, int j, int f);
        return s * 672 + 'h30 + j * 20 + f;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int unsigned a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int unsigned a, output logic [31:0] d);
        reg_addr = 12'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic prog_slot(int s, int j, logic [31:0] m, logic [31:0] ad, logic [31:0] dt);
        wr(a_slot(s, j, 0), m);
        wr(a_slot(s, j, 4), ad);
        wr(a_slot(s, j, 8), dt);
    endtask

    // Driver side of the scoreboard: push one expected bus item.
    task automatic expect_cmd(logic [31:0] ad, logic [31:0] dt, logic [31:0] m);
        exp_q.push_back({ad, dt, m});
    endtask

    // Retrigger sequence: drop trigger, drop enable, set enable, set trigger.
    task automatic arm(int s);
        wr(a_set(s, 'h14), 32'h0001_0000);
        wr(a_set(s, 'h14), 32'h0000_0000);
        wr(a_set(s, 'h14), 32'h0001_0000);
        wr(a_set(s, 'h14), 32'h0101_0000);
    endtask

    task automatic wait_idle(int s);
        logic [31:0] v;
        int k = 0;
        do begin
            @(negedge clk);
            rd(a_set(s, 'h18), v);
            k++;
        end while (v[0] == 1'b0 && k < 3000);
    endtask

    // Responder model: grant after gnt_delay, answer rr commands after rsp_delay.
    int gcnt = 0, rcnt = 0;
    logic [31:0] rsp_hold = '0;
    always @(negedge clk) begin
        cmd_gnt = 1'b0;
        cmd_rsp_vld = 1'b0;
        if (!rst_n) begin
            gcnt = 0; rcnt = 0;
        end else if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin
                cmd_rsp_vld = 1'b1;
                cmd_rsp_data = rsp_hold;
            end
        end else if (cmd_req) begin
            if (gcnt >= gnt_delay) begin
                cmd_gnt = 1'b1;
                gcnt = 0;
                if (cmd_msgid[8]) begin
                    rcnt = rsp_delay;
                    rsp_hold = cmd_addr ^ RSP_X;
                end
            end else begin
                gcnt++;
            end
        end
    end

    // Monitor side of the scoreboard: compare every accepted command.
    always @(negedge clk) begin
        #1;
        if (rst_n && cmd_req && cmd_gnt) begin
            n_gnt++;
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R3: unexpected command actual addr %h expected none", cmd_addr);
            end else begin
                logic [95:0] e;
                e = exp_q.pop_front();
                chk("R3 command address order", cmd_addr, e[95:64]);
                chk("R3 command data", cmd_data, e[63:32]);
                chk("R5 command message", cmd_msgid, e[31:0]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int g0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(a_set(0, 'h18), v); chk("R1 reset set status idle", v, 32'h1);
        rd(a_set(1, 'h14), v); chk("R1 reset control", v, 32'h0);
        rd(a_slot(2, 3, 'h10), v); chk("R1 reset response", v, 32'h0);
        chk("R1 reset irq/req", {30'b0, irq, cmd_req}, 32'h0);

        // R1 map readback
        prog_slot(0, 0, 32'h0001_0001, 32'hA000_0000, 32'hD000_0000);
        rd(a_slot(0, 0, 4), v); chk("R1 slot address readback", v, 32'hA000_0000);
        prog_slot(0, 1, 32'h0001_0101, 32'hA000_0001, 32'hD000_0001);
        prog_slot(0, 2, 32'h0001_0001, 32'hA000_0002, 32'hD000_0002);
        prog_slot(0, 3, 32'h0001_0001, 32'hA000_0003, 32'hD000_0003);
        wr(a_set(0, 'h1C), 32'hB);
        rd(a_set(0, 'h1C), v); chk("R1 enable mask readback", v, 32'hB);

        // R3 R5 R6 R8 main run, slot 2 skipped
        expect_cmd(32'hA000_0000, 32'hD000_0000, 32'h0001_0001);
        expect_cmd(32'hA000_0001, 32'hD000_0001, 32'h0001_0101);
        expect_cmd(32'hA000_0003, 32'hD000_0003, 32'h0001_0001);
        arm(0);
        wait_idle(0);
        chk("R3 all expected commands issued", 32'(exp_q.size()), 32'h0);
        rd(a_slot(0, 0, 'hC), v); chk("R6 slot0 status", v, ST_DONE);
        rd(a_slot(0, 1, 'hC), v); chk("R6 slot1 status", v, ST_DONE);
        rd(a_slot(0, 2, 'hC), v); chk("R6 disabled slot2 status", v, 32'h0);
        rd(a_slot(0, 3, 'hC), v); chk("R6 slot3 status", v, ST_DONE);
        rd(a_slot(0, 1, 'h10), v); chk("R5 response captured", v, 32'hA000_0001 ^ RSP_X);
        rd(a_set(0, 4), v); chk("R8 irq status set", v, 32'h1);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(a_set(0, 0), 32'h7);
        chk("R8 irq enabled", {31'b0, irq}, 32'h1);
        wr(a_set(0, 8), 32'h1);
        rd(a_set(0, 4), v); chk("R8 w1c clears status", v, 32'h0);
        chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R2 start qualification
        prog_slot(1, 0, 32'h0001_0001, 32'hB000_0000, 32'hE000_0000);
        wr(a_set(1, 'h1C), 32'h1);
        g0 = n_gnt;
        wr(a_set(1, 'h14), 32'h0101_0000);
        repeat (10) @(negedge clk);
        rd(a_set(1, 'h18), v); chk("R2 enable+trigger together no start", v, 32'h1);
        wr(a_set(1, 'h14), 32'h0);
        wr(a_set(1, 'h14), 32'h0100_0000);
        repeat (10) @(negedge clk);
        rd(a_set(1, 'h18), v); chk("R2 trigger without enable no start", v, 32'h1);
        chk("R2 no commands issued", 32'(n_gnt - g0), 32'h0);
        expect_cmd(32'hB000_0000, 32'hE000_0000, 32'h0001_0001);
        arm(1);
        wait_idle(1);
        chk("R2 proper arm ran", 32'(n_gnt - g0), 32'h1);

        // R7 busy behaviour
        gnt_delay = 30;
        expect_cmd(32'hA000_0000, 32'hD000_0000, 32'h0001_0001);
        expect_cmd(32'hA000_0001, 32'hD000_0001, 32'h0001_0101);
        expect_cmd(32'hA000_0003, 32'hD000_0003, 32'h0001_0001);
        arm(0);
        rd(a_set(0, 'h18), v); chk("R7 status zero while busy", v, 32'h0);
        wr(a_slot(0, 0, 4), 32'hFFFF_FFFF);
        wr(a_set(0, 'h1C), 32'h0);
        wait_idle(0);
        gnt_delay = 0;
        rd(a_slot(0, 0, 4), v); chk("R7 slot write ignored when busy", v, 32'hA000_0000);
        rd(a_set(0, 'h1C), v); chk("R7 enable write ignored when busy", v, 32'hB);
        rd(a_slot(0, 0, 'hC), v); chk("R7 status kept after busy enable write", v, ST_DONE);

        // R9 clear on enable-zero, R5 wait mask forces response
        wr(a_set(1, 'h1C), 32'h2);
        rd(a_slot(1, 0, 'hC), v); chk("R9 slot status cleared", v, 32'h0);
        prog_slot(1, 1, 32'h0001_0002, 32'hB000_0001, 32'hE000_0001);
        wr(a_set(1, 'h10), 32'h2);
        expect_cmd(32'hB000_0001, 32'hE000_0001, 32'h0001_0102);
        arm(1);
        wait_idle(1);
        rd(a_slot(1, 1, 'h10), v); chk("R5 wait-mask response captured", v, 32'hB000_0001 ^ RSP_X);
        rd(a_slot(1, 1, 'hC), v); chk("R6 wait-mask slot status", v, ST_DONE);

        // R8 set with no enabled slot finishes at once
        g0 = n_gnt;
        wr(a_set(0, 8), 32'h7);
        arm(2);
        wait_idle(2);
        rd(a_set(0, 4), v); chk("R8 empty set raises status", v[2] ? 32'h1 : 32'h0, 32'h1);
        chk("R8 empty set issues nothing", 32'(n_gnt - g0), 32'h0);
        chk("R8 irq line with enable", {31'b0, irq}, 32'h1);
        wr(a_set(0, 8), 32'h7);

        // R10 lowest waiting set first
        wr(a_set(0, 'h1C), 32'h1);
        rd(a_slot(0, 3, 'hC), v); chk("R9 slot3 status cleared", v, 32'h0);
        prog_slot(2, 0, 32'h0001_0001, 32'hC000_0000, 32'hF000_0000);
        wr(a_set(2, 'h1C), 32'h1);
        gnt_delay = 40;
        expect_cmd(32'hC000_0000, 32'hF000_0000, 32'h0001_0001);
        expect_cmd(32'hA000_0000, 32'hD000_0000, 32'h0001_0001);
        expect_cmd(32'hB000_0001, 32'hE000_0001, 32'h0001_0102);
        arm(2);
        arm(1);
        arm(0);
        wait_idle(2);
        wait_idle(0);
        wait_idle(1);
        chk("R10 all queued sets served", 32'(exp_q.size()), 32'h0);
        rd(a_set(0, 4), v); chk("R10 done status of all sets", v, 32'h7);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule